// File: doc/BRIEF.md
# Conversion Mode and Status Sequencer

This block runs the operating modes of a sigma-delta converter around a stubbed modulator and filter. A 3-bit mode field picks between free-running conversion, one-shot conversion, idle, power-down and four calibration kinds. A 4-bit rate code picks the output period, which is counted in system-clock ticks. At the end of the right number of periods the block captures the filter's raw word. It stores that word, clamped where needed, as a conversion result, or it stores it as an offset or full-scale coefficient.

The block keeps the status byte and the ready indication that a host polls before it reads a result. It drops ready just before each new result lands, so a read never overlaps an update. Calibrations park the converter in idle when they finish, and a one-shot conversion returns to power-down. Coefficient registers can be written directly, but only while the converter is stopped.

Top module: `conv_seq_top`

## Requirements
- R1: Mode codes are 000 continuous, 001 single, 010 idle, 011 power-down, 100 internal zero-scale calibration, 101 internal full-scale calibration, 110 system offset calibration and 111 system full-scale calibration. After reset the mode is 000, the status byte is 0x88, the data register is 0, the offset register is 0x800000 and the full-scale register is 0x500000.
- R2: One period is TICK_UNIT system cycles times a multiplier set by the rate code. Codes 1, 2 and 3 use multipliers 1, 2 and 4. Code 15 uses 120, and code 0, which is unused, behaves like code 15. In continuous mode the first result (done_out pulse) comes 2 periods after reset, after an accepted mode write or after cfg_wr. Each later result comes 1 period after the one before.
- R3: Single mode gives one result 2 periods after the write and then shows mode 011. The result and the ready state are then held with no further done_out.
- R4: Calibrations take 2 periods, except internal full-scale at a gain code other than 000, which takes 4. Modes 100 and 110 store raw_result into the offset register, and modes 101 and 111 store it into the full-scale register. Ready goes inactive at the write and active at completion, and the mode then reads 010.
- R5: A write of mode 101 while gain_code is 111 is ignored: the mode and the ready state do not change.
- R6: status_out is {not-ready, error, no-reference, 0, 1 for a data width above 16 bits, chan_sel[2:0]}. Bit 7 is 0 while a result is pending. done_out is high for one cycle with each stored result or coefficient.
- R7: A result with ref_missing is stored as all ones, one with over_range as all ones and one with under_range as all zeros. ref_missing takes priority over the other two. Any of the three sets the error bit, and ref_missing also sets the no-reference bit.
- R8: An accepted write of mode 000 or 001 clears the error and no-reference bits.
- R9: Ready becomes inactive on data_rd, on any accepted mode write (including entry to power-down), and GUARD cycles before the result cycle of a pending conversion.
- R10: off_wr and fs_wr load coef_wdata only when the mode is 010 or 011. In any other mode they are ignored.
- R11: psw_out follows psw_bit, but it is forced to 0 while the mode is 011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 3 | Mode code to write |
| cfg_wr | input | 1 | Configuration or IO register write strobe |
| rate_code | input | 4 | Output rate code |
| gain_code | input | 3 | Amplifier gain code |
| chan_sel | input | 3 | Active channel |
| psw_bit | input | 1 | Low-side switch control bit as written |
| data_rd | input | 1 | Data register read strobe |
| off_wr | input | 1 | Offset register write strobe |
| fs_wr | input | 1 | Full-scale register write strobe |
| coef_wdata | input | W | Coefficient write data |
| raw_result | input | W | Filter output word |
| over_range | input | 1 | Filter over-range flag |
| under_range | input | 1 | Filter under-range flag |
| ref_missing | input | 1 | Reference detector flag |
| data_out | output | W | Data register |
| off_out | output | W | Offset register |
| fs_out | output | W | Full-scale register |
| status_out | output | 8 | Status byte |
| mode_out | output | 3 | Current mode |
| psw_out | output | 1 | Low-side switch drive |
| done_out | output | 1 | Result or coefficient stored |

## Verification
The main conversion path is run over a vector table that mixes rate codes 0, 1, 2 and 3 with clean, over-range, under-range and reference-missing words. This separates period scaling errors from clamp-priority errors and from status packing errors on several channels. Directed sequences then time the 2-period first result against the 1-period steady state and the guard-window drop of ready. They also cover each calibration kind with its destination register and duration, and the rejected gain-128 full-scale calibration. Coefficient writes are tried in stopped and running modes, and the switch drive is checked across power-down.

// File: rtl/conv_seq_pkg.sv
// Package: shared mode type and rate lookup for the conversion sequencer.
// Assumes rate codes are 4 bits; code 0 is mapped to the slowest rate.
package conv_seq_pkg;

    typedef enum logic [2:0] {
        M_CONT   = 3'd0,
        M_SINGLE = 3'd1,
        M_IDLE   = 3'd2,
        M_PDOWN  = 3'd3,
        M_ZCAL   = 3'd4,
        M_FCAL   = 3'd5,
        M_SOFF   = 3'd6,
        M_SFS    = 3'd7
    } mode_e;

    localparam int unsigned MAX_MULT = 120;

    // Period length of a rate code, in units of the base tick count.
    function automatic int unsigned rate_mult(input logic [3:0] code);
        case (code)
            4'd1:    rate_mult = 1;
            4'd2:    rate_mult = 2;
            4'd3:    rate_mult = 4;
            4'd4:    rate_mult = 8;
            4'd5:    rate_mult = 10;
            4'd6:    rate_mult = 13;
            4'd7:    rate_mult = 15;
            4'd8:    rate_mult = 26;
            4'd9:    rate_mult = 30;
            4'd10:   rate_mult = 30;
            4'd11:   rate_mult = 40;
            4'd12:   rate_mult = 50;
            4'd13:   rate_mult = 60;
            4'd14:   rate_mult = 80;
            default: rate_mult = MAX_MULT;
        endcase
    endfunction

endpackage

// File: rtl/conv_rate_timer.sv
// Module: conv_rate_timer
// Counts system cycles through one output period chosen by the rate code.
// Flags the last cycle of each period and the cycle GUARD cycles before it.
// Assumes TICK_UNIT > GUARD so the guard cycle exists in every period.
module conv_rate_timer
    import conv_seq_pkg::*;
#(
    parameter int unsigned TICK_UNIT = 8,
    parameter int unsigned GUARD     = 2,
    parameter int unsigned CW        = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       run,
    input  logic [3:0] rate,
    output logic       period_end,
    output logic       guard_hit
);

    logic [CW-1:0] cnt;
    logic [CW-1:0] len;
    logic          live;

    // Period length of the current rate code.
    always_comb len = CW'(TICK_UNIT * rate_mult(rate));

    // Timer runs only when enabled and not being restarted this cycle.
    always_comb live = run && !restart;

    // End-of-period and guard-window flags.
    always_comb begin
        period_end = live && (cnt >= len - CW'(1));
        guard_hit  = live && (cnt == len - CW'(GUARD + 1));
    end

    // Tick counter: cleared by restart or stop, wraps at the period end.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (!live)      cnt <= '0;
        else if (period_end) cnt <= '0;
        else                 cnt <= cnt + CW'(1);
    end

endmodule

// File: rtl/conv_mode_fsm.sv
// Module: conv_mode_fsm
// Holds the current mode and counts the periods left until the next event.
// Raises one-cycle conversion or calibration events. It moves single mode
// to power-down and calibrations to idle when they finish.
// Assumes period_end is already gated by run and restart.
module conv_mode_fsm
    import conv_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_wr,
    input  logic [2:0] mode_wdata,
    input  logic       cfg_wr,
    input  logic [2:0] gain_code,
    input  logic       period_end,
    output mode_e      mode_q,
    output logic       restart,
    output logic       run,
    output logic       last_period,
    output logic       mode_acc,
    output logic       conv_start,
    output logic       ev_conv,
    output logic       ev_off,
    output logic       ev_fs
);

    localparam logic [2:0] GAIN_MAX = 3'b111;

    logic [2:0] pcnt;
    logic [2:0] first_len;
    logic       fcal_block;
    logic       fire;
    mode_e      wmode;

    // Decode the written mode and refuse full-scale calibration at top gain.
    always_comb begin
        wmode      = mode_e'(mode_wdata);
        fcal_block = (wmode == M_FCAL) && (gain_code == GAIN_MAX);
        mode_acc   = mode_wr && !fcal_block;
        conv_start = mode_acc && ((wmode == M_CONT) || (wmode == M_SINGLE));
    end

    // Periods needed before the first event of the newly written mode.
    always_comb begin
        if (wmode == M_FCAL && gain_code != 3'b000) first_len = 3'd4;
        else                                        first_len = 3'd2;
    end

    // Timer control and event decode.
    always_comb begin
        restart     = mode_acc || (cfg_wr && mode_q == M_CONT);
        run         = (mode_q != M_IDLE) && (mode_q != M_PDOWN);
        last_period = run && (pcnt == 3'd1);
        fire        = period_end && last_period;
        ev_conv     = fire && ((mode_q == M_CONT) || (mode_q == M_SINGLE));
        ev_off      = fire && ((mode_q == M_ZCAL) || (mode_q == M_SOFF));
        ev_fs       = fire && ((mode_q == M_FCAL) || (mode_q == M_SFS));
    end

    // Mode register and remaining-period counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= M_CONT;
            pcnt   <= 3'd2;
        end else if (mode_acc) begin
            mode_q <= wmode;
            pcnt   <= first_len;
        end else if (cfg_wr && mode_q == M_CONT) begin
            pcnt   <= 3'd2;
        end else if (period_end) begin
            if (last_period) begin
                case (mode_q)
                    M_CONT:   pcnt   <= 3'd1;
                    M_SINGLE: mode_q <= M_PDOWN;
                    default:  mode_q <= M_IDLE;
                endcase
            end else begin
                pcnt <= pcnt - 3'd1;
            end
        end
    end

endmodule

// File: rtl/conv_result_regs.sv
// Module: conv_result_regs
// Data, offset and full-scale registers, the clamp and the status flags.
// Assumes at most one event input is high in any cycle.
module conv_result_regs #(
    parameter int unsigned W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ev_conv,
    input  logic         ev_off,
    input  logic         ev_fs,
    input  logic         guard_clr,
    input  logic         data_rd,
    input  logic         mode_acc,
    input  logic         conv_start,
    input  logic         coef_ok,
    input  logic         off_wr,
    input  logic         fs_wr,
    input  logic [W-1:0] coef_wdata,
    input  logic [W-1:0] raw,
    input  logic         ovr,
    input  logic         und,
    input  logic         noref,
    input  logic [2:0]   chan,
    output logic [W-1:0] data_q,
    output logic [W-1:0] off_q,
    output logic [W-1:0] fs_q,
    output logic [7:0]   status,
    output logic         done
);

    localparam logic [W-1:0] OFF_INIT = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] FS_INIT  = {4'h5, {(W-4){1'b0}}};
    localparam logic         WIDE     = (W > 16);

    logic [W-1:0] clamped;
    logic         pending;
    logic         err_q;
    logic         noref_q;
    logic         ev_any;

    // Clamp the raw word: missing reference first, then range flags.
    always_comb begin
        if (noref || ovr) clamped = '1;
        else if (und)     clamped = '0;
        else              clamped = raw;
        ev_any = ev_conv || ev_off || ev_fs;
    end

    // Status byte packing; bit 7 is the inverted pending flag.
    always_comb status = {~pending, err_q, noref_q, 1'b0, WIDE, chan};

    // Pending flag: set by a stored event, cleared by read, write or guard.
    always_ff @(posedge clk) begin
        if (!rst_n)                               pending <= 1'b0;
        else if (ev_any)                          pending <= 1'b1;
        else if (mode_acc || data_rd || guard_clr) pending <= 1'b0;
    end

    // Error and no-reference flags, updated with each conversion result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q   <= 1'b0;
            noref_q <= 1'b0;
        end else if (ev_conv) begin
            err_q   <= ovr || und || noref;
            noref_q <= noref;
        end else if (conv_start) begin
            err_q   <= 1'b0;
            noref_q <= 1'b0;
        end
    end

    // Data register captures the clamped result.
    always_ff @(posedge clk) begin
        if (!rst_n)       data_q <= '0;
        else if (ev_conv) data_q <= clamped;
    end

    // Offset coefficient: calibration result or a write while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)                  off_q <= OFF_INIT;
        else if (ev_off)             off_q <= raw;
        else if (off_wr && coef_ok)  off_q <= coef_wdata;
    end

    // Full-scale coefficient: calibration result or a write while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)                  fs_q <= FS_INIT;
        else if (ev_fs)              fs_q <= raw;
        else if (fs_wr && coef_ok)   fs_q <= coef_wdata;
    end

    // One-cycle pulse alongside every stored result or coefficient.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= ev_any;
    end

endmodule

// File: rtl/conv_seq_top.sv
// Module: conv_seq_top
// Top of the conversion mode and status sequencer: timer, mode FSM and
// result registers. Assumes the filter stub presents raw_result and its
// flags steadily around each period end.
module conv_seq_top
    import conv_seq_pkg::*;
#(
    parameter int unsigned W         = 24,
    parameter int unsigned TICK_UNIT = 8,
    parameter int unsigned GUARD     = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_wr,
    input  logic [2:0]   mode_wdata,
    input  logic         cfg_wr,
    input  logic [3:0]   rate_code,
    input  logic [2:0]   gain_code,
    input  logic [2:0]   chan_sel,
    input  logic         psw_bit,
    input  logic         data_rd,
    input  logic         off_wr,
    input  logic         fs_wr,
    input  logic [W-1:0] coef_wdata,
    input  logic [W-1:0] raw_result,
    input  logic         over_range,
    input  logic         under_range,
    input  logic         ref_missing,
    output logic [W-1:0] data_out,
    output logic [W-1:0] off_out,
    output logic [W-1:0] fs_out,
    output logic [7:0]   status_out,
    output logic [2:0]   mode_out,
    output logic         psw_out,
    output logic         done_out
);

    localparam int unsigned CW = $clog2(TICK_UNIT * MAX_MULT + 1);

    mode_e mode_q;
    logic  restart, run, last_period, mode_acc, conv_start;
    logic  ev_conv, ev_off, ev_fs;
    logic  period_end, guard_hit, coef_ok;

    conv_rate_timer #(.TICK_UNIT(TICK_UNIT), .GUARD(GUARD), .CW(CW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .run        (run),
        .rate       (rate_code),
        .period_end (period_end),
        .guard_hit  (guard_hit)
    );

    conv_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_wr     (mode_wr),
        .mode_wdata  (mode_wdata),
        .cfg_wr      (cfg_wr),
        .gain_code   (gain_code),
        .period_end  (period_end),
        .mode_q      (mode_q),
        .restart     (restart),
        .run         (run),
        .last_period (last_period),
        .mode_acc    (mode_acc),
        .conv_start  (conv_start),
        .ev_conv     (ev_conv),
        .ev_off      (ev_off),
        .ev_fs       (ev_fs)
    );

    // Coefficient writes are allowed only while the converter is stopped.
    always_comb coef_ok = (mode_q == M_IDLE) || (mode_q == M_PDOWN);

    conv_result_regs #(.W(W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_conv    (ev_conv),
        .ev_off     (ev_off),
        .ev_fs      (ev_fs),
        .guard_clr  (guard_hit && last_period),
        .data_rd    (data_rd),
        .mode_acc   (mode_acc),
        .conv_start (conv_start),
        .coef_ok    (coef_ok),
        .off_wr     (off_wr),
        .fs_wr      (fs_wr),
        .coef_wdata (coef_wdata),
        .raw        (raw_result),
        .ovr        (over_range),
        .und        (under_range),
        .noref      (ref_missing),
        .chan       (chan_sel),
        .data_q     (data_out),
        .off_q      (off_out),
        .fs_q       (fs_out),
        .status     (status_out),
        .done       (done_out)
    );

    // Mode view and the switch drive, which power-down forces open.
    always_comb begin
        mode_out = mode_q;
        psw_out  = psw_bit && (mode_q != M_PDOWN);
    end

endmodule

// File: rtl/conv_seq_checker.sv
// Module: conv_seq_checker
// Temporal checks on the sequencer, bound to every conv_seq_top instance.
module conv_seq_checker #(
    parameter int unsigned W = 24
) (
    input logic         clk,
    input logic         rst_n,
    input logic         mode_wr,
    input logic [2:0]   mode_wdata,
    input logic [2:0]   gain_code,
    input logic         data_rd,
    input logic         off_wr,
    input logic         ref_missing,
    input logic [W-1:0] data_out,
    input logic [W-1:0] off_out,
    input logic [7:0]   status_out,
    input logic [2:0]   mode_out,
    input logic         psw_out,
    input logic         done_out,
    input logic         ev_conv,
    input logic         ev_off,
    input logic         ev_fs
);

    assert_pdown_switch_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_out == 3'd3) |-> !psw_out);

    assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !(ev_conv || ev_off || ev_fs)) |=> status_out[7]);

    assert_cal_parks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_off || ev_fs) |=> (mode_out == 3'd2));

    assert_noref_clamp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_conv && ref_missing) |=> ((data_out == {W{1'b1}}) && status_out[6] && status_out[5]));

    assert_coef_guard_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (off_wr && mode_out != 3'd2 && mode_out != 3'd3 && !ev_off) |=> $stable(off_out));

    assert_fcal_reject_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && mode_wdata == 3'd5 && gain_code == 3'd7 && !(ev_conv || ev_off || ev_fs))
        |=> $stable(mode_out));

    assert_done_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_out |-> !status_out[7]);

endmodule

bind conv_seq_top conv_seq_checker #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_wr     (mode_wr),
    .mode_wdata  (mode_wdata),
    .gain_code   (gain_code),
    .data_rd     (data_rd),
    .off_wr      (off_wr),
    .ref_missing (ref_missing),
    .data_out    (data_out),
    .off_out     (off_out),
    .status_out  (status_out),
    .mode_out    (mode_out),
    .psw_out     (psw_out),
    .done_out    (done_out),
    .ev_conv     (ev_conv),
    .ev_off      (ev_off),
    .ev_fs       (ev_fs)
);

// File: tb/tb_conv_seq_top.sv
module tb_conv_seq_top;

    localparam int W  = 24;
    localparam int TU = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_wr = 0, cfg_wr = 0, psw_bit = 0, data_rd = 0;
    logic         off_wr = 0, fs_wr = 0;
    logic [2:0]   mode_wdata = 0, gain_code = 0, chan_sel = 0;
    logic [3:0]   rate_code = 4'd1;
    logic [W-1:0] coef_wdata = 0, raw_result = 0;
    logic         over_range = 0, under_range = 0, ref_missing = 0;
    logic [W-1:0] data_out, off_out, fs_out;
    logic [7:0]   status_out;
    logic [2:0]   mode_out;
    logic         psw_out, done_out;

    int checks = 0, fails = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    conv_seq_top #(.W(W), .TICK_UNIT(TU), .GUARD(2)) dut (.*);

    // {rate, chan, ovr, und, noref, raw, expected data, expected status}
    localparam int NV = 5;
    localparam logic [65:0] VEC [NV] = '{
        {4'd1, 3'd1, 3'b000, 24'h123456, 24'h123456, 8'h09},
        {4'd2, 3'd2, 3'b100, 24'h00ABCD, 24'hFFFFFF, 8'h4A},
        {4'd3, 3'd3, 3'b010, 24'h777777, 24'h000000, 8'h4B},
        {4'd1, 3'd4, 3'b011, 24'h000001, 24'hFFFFFF, 8'h6C},
        {4'd0, 3'd0, 3'b000, 24'h654321, 24'h654321, 8'h08}
    };

    function automatic int mult_of(input logic [3:0] c);
        case (c)
            4'd1: return 1;
            4'd2: return 2;
            4'd3: return 4;
            default: return 120;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic write_mode(input logic [2:0] m);
        @(negedge clk);
        mode_wdata = m;
        mode_wr = 1'b1;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    // Counts rising edges until done_out is seen after one of them.
    task automatic wait_done(output int n);
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end while (!done_out && n < 5000);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int n;
        step(3);
        // R1 reset state
        chk(status_out == 8'h88, "R1 status", status_out, 8'h88);
        chk(data_out == 0 && mode_out == 0, "R1 data/mode", {data_out[23:0], 5'b0, mode_out}, 0);
        chk(off_out == 24'h800000, "R1 offset", off_out, 24'h800000);
        chk(fs_out == 24'h500000, "R1 fullscale", fs_out, 24'h500000);
        rst_n = 1'b1;
        raw_result = 24'h0000C3;
        // R2 first result after reset: two periods
        wait_done(n);
        chk(n == 2 * TU, "R2 first after reset", n, 2 * TU);
        chk(data_out == 24'h0000C3, "R2 data", data_out, 24'h0000C3);
        // R2 steady state: one period
        wait_done(n);
        chk(n == TU, "R2 steady period", n, TU);
        // R9 guard window drops ready before the next result
        step(5);
        chk(status_out[7] == 1'b0, "R9 ready before guard", status_out[7], 0);
        step(1);
        chk(status_out[7] == 1'b1, "R9 guard clears ready", status_out[7], 1);
        wait_done(n);
        chk(n == 2, "R2 result after guard", n, 2);
        // R9 data read clears ready
        data_rd = 1'b1;
        step(1);
        data_rd = 1'b0;
        chk(status_out[7] == 1'b1, "R9 read clears ready", status_out[7], 1);
        // R2 cfg write restarts the two-period wait
        step(2);
        cfg_wr = 1'b1;
        step(1);
        cfg_wr = 1'b0;
        wait_done(n);
        chk(n == 2 * TU, "R2 cfg restart", n, 2 * TU);

        // Vector table: rates, clamp and status packing (R2 R6 R7 R8)
        for (int i = 0; i < NV; i++) begin
            logic [65:0] v;
            v = VEC[i];
            @(negedge clk);
            rate_code = v[65:62];
            chan_sel = v[61:59];
            over_range = v[58];
            under_range = v[57];
            ref_missing = v[56];
            raw_result = v[55:32];
            write_mode(3'd0);
            wait_done(n);
            chk(n == 2 * TU * mult_of(v[65:62]), "R2 rate period", n, 2 * TU * mult_of(v[65:62]));
            chk(data_out == v[31:8], "R7 clamp", data_out, v[31:8]);
            chk(status_out == v[7:0], "R6 R8 status", status_out, v[7:0]);
        end

        // R3 single conversion then power-down, result held
        @(negedge clk);
        rate_code = 4'd1; chan_sel = 0;
        over_range = 0; under_range = 0; ref_missing = 0;
        raw_result = 24'h0000AA;
        psw_bit = 1'b1;
        write_mode(3'd1);
        wait_done(n);
        chk(n == 2 * TU, "R3 single time", n, 2 * TU);
        chk(data_out == 24'h0000AA, "R3 single data", data_out, 24'h0000AA);
        step(1);
        chk(mode_out == 3'd3, "R3 back to power-down", mode_out, 3);
        step(40);
        chk(status_out[7] == 1'b0 && !done_out, "R3 result held", status_out[7], 0);
        chk(psw_out == 1'b0, "R11 switch open in power-down", psw_out, 0);
        // R10 coefficient write accepted in power-down
        @(negedge clk);
        coef_wdata = 24'h111111; off_wr = 1'b1;
        step(1);
        off_wr = 1'b0;
        chk(off_out == 24'h111111, "R10 offset write in power-down", off_out, 24'h111111);
        // R9 mode write clears ready, R11 switch follows bit in idle
        write_mode(3'd2);
        chk(status_out[7] == 1'b1, "R9 mode write clears ready", status_out[7], 1);
        chk(psw_out == 1'b1, "R11 switch in idle", psw_out, 1);

        // R4 calibrations
        raw_result = 24'h000321;
        write_mode(3'd4);
        chk(status_out[7] == 1'b1, "R4 ready inactive at start", status_out[7], 1);
        wait_done(n);
        chk(n == 2 * TU && off_out == 24'h000321, "R4 zero-scale", off_out, 24'h000321);
        chk(mode_out == 3'd2, "R4 parks idle", mode_out, 2);
        raw_result = 24'h400100;
        write_mode(3'd5);
        wait_done(n);
        chk(n == 2 * TU && fs_out == 24'h400100, "R4 int full-scale gain 1", n, 2 * TU);
        gain_code = 3'd1;
        raw_result = 24'h400200;
        write_mode(3'd5);
        wait_done(n);
        chk(n == 4 * TU && fs_out == 24'h400200, "R4 int full-scale gain 2", n, 4 * TU);
        // R5 rejected at gain code 111
        gain_code = 3'd7;
        write_mode(3'd5);
        step(2);
        chk(mode_out == 3'd2 && status_out[7] == 1'b0, "R5 write ignored", {status_out, 5'b0, mode_out}, 2);
        gain_code = 3'd0;
        raw_result = 24'h000099;
        write_mode(3'd6);
        wait_done(n);
        chk(n == 2 * TU && off_out == 24'h000099, "R4 system offset", off_out, 24'h000099);
        raw_result = 24'h3FFF00;
        write_mode(3'd7);
        wait_done(n);
        chk(n == 2 * TU && fs_out == 24'h3FFF00, "R4 system full-scale", fs_out, 24'h3FFF00);
        step(1);
        chk(mode_out == 3'd2, "R4 idle after system cal", mode_out, 2);

        // R10 coefficient writes ignored while converting
        write_mode(3'd0);
        @(negedge clk);
        coef_wdata = 24'h222222; off_wr = 1'b1; fs_wr = 1'b1;
        step(1);
        off_wr = 1'b0; fs_wr = 1'b0;
        chk(off_out == 24'h000099, "R10 offset write ignored", off_out, 24'h000099);
        chk(fs_out == 24'h3FFF00, "R10 fullscale write ignored", fs_out, 24'h3FFF00);

        // R8 error cleared by a conversion-starting write
        over_range = 1'b1;
        write_mode(3'd0);
        wait_done(n);
        chk(status_out[6] == 1'b1, "R7 error set", status_out[6], 1);
        over_range = 1'b0;
        write_mode(3'd1);
        chk(status_out[6] == 1'b0, "R8 error cleared", status_out[6], 0);

        step(4);
        finish_run();
    end

endmodule